// File: doc/BRIEF.md
# Serial Command Port for a Byte Register Space

This block is a serial-peripheral slave that lets an external host reach a 128-byte register file through a fixed set of one-byte instructions. It runs on the chip clock. It oversamples the serial clock, chip select and data-in lines through synchronizers, and it detects serial clock edges in the chip clock domain. The serial clock may idle low or high (SPI modes 0,0 and 1,1). Each phase of the serial clock must last at least six chip clock cycles.

After chip select falls, the first byte is decoded as an instruction. The following bytes are then handled according to that instruction:

- **Read and write:** both take an address and then stream data with an auto-incrementing address.
- **Bit modify:** takes an address, a mask and a data byte, and performs a read-modify-write.
- **Status:** streams a packed byte of interrupt and transmit-request flags.
- **Request-to-send:** pulses one transmit-request strobe for each set bit in the opcode's low field.
- **Soft reset:** pulses a reset strobe once chip select is released.

The register file behind the port has a registered read: read data belongs to the address presented one cycle earlier.

Top module: `spi_cmd_port`

## Requirements
- R1: Opcodes are 0x03 read, 0x02 write, 0x05 bit modify, 0xA0 status, 0xC0 soft reset and 0b10000nnn request-to-send; any other first byte is ignored, so no register is written, no strobe fires and SO stays undriven until chip select rises.
- R2: SI is captured on each rising serial clock edge while chip select is low, and SO moves to the next bit after a falling edge. This works with the serial clock idling low or high.
- R3: After opcode 0x03 and an address byte, every following byte returns the register at the current address, most significant bit first, and the address then steps by one, wrapping from 0x7F to 0x00.
- R4: After opcode 0x02 and an address byte, each complete data byte is written to the current address, which then steps by one with the same wrap.
- R5: Bit modify (0x05, address, mask, data) replaces only the register bits whose mask bit is 1 with the data bits; a zero mask leaves the register unchanged.
- R6: After opcode 0xA0, each following byte returns the status byte. From bit 0 upward it holds: RX0 flag, RX1 flag, TX0 request, TX0 flag, TX1 request, TX1 flag, TX2 request, TX2 flag.
- R7: Opcode 0b10000nnn raises rtsPulse[i] for exactly one clock cycle for each bit i set in nnn, and raises nothing when nnn is zero.
- R8: Opcode 0xC0 raises softReset for exactly one clock cycle after chip select is released, and never while chip select is still low.
- R9: spiSoOe is low while chip select is high, and low during the instruction and address bytes.
- R10: Raising chip select in the middle of a byte discards the partial byte, so nothing is written, and the next transaction starts with a fresh instruction byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Chip clock |
| rst | input | 1 | Synchronous reset, active high |
| spiSck | input | 1 | Serial clock from the host |
| spiCsN | input | 1 | Chip select, active low |
| spiSi | input | 1 | Serial data from the host |
| spiSo | output | 1 | Serial data to the host |
| spiSoOe | output | 1 | Drive enable for spiSo; low means high impedance |
| regAddr | output | ADDR_W | Register file address |
| regWrData | output | 8 | Register file write data |
| regWe | output | 1 | Register file write enable |
| regRdData | input | 8 | Register file read data, valid one cycle after regAddr |
| rxIntFlag | input | 2 | Receive-buffer interrupt flags |
| txReqFlag | input | 3 | Transmit-buffer request flags |
| txIntFlag | input | 3 | Transmit-buffer interrupt flags |
| rtsPulse | output | 3 | One-cycle transmit request strobes |
| softReset | output | 1 | One-cycle soft-reset strobe |

## Verification
The hardest situation to reach is the byte-boundary hand-off on SO. The next read byte must be fetched, through the two-cycle register read, before the falling serial clock edge that opens the next byte, and that edge must not shift the freshly loaded byte. The stimulus streams multi-byte reads across the 0x7F to 0x00 wrap with both serial clock idle levels, so the boundary falls at both possible clock phases. A partial byte is cut off by raising chip select, both inside a write's data byte and inside an instruction byte, to show that the bit counter restarts cleanly.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int BYTE_W  = 8;
  localparam int TX_BUFS = 3;

  localparam logic [7:0] OPC_READ   = 8'h03;
  localparam logic [7:0] OPC_WRITE  = 8'h02;
  localparam logic [7:0] OPC_MODIFY = 8'h05;
  localparam logic [7:0] OPC_STATUS = 8'hA0;
  localparam logic [7:0] OPC_RESET  = 8'hC0;
  localparam logic [4:0] OPC_RTS_HI = 5'b10000;

  typedef enum logic [3:0] {
    ST_OPCODE,
    ST_ADDR,
    ST_RDDATA,
    ST_WRDATA,
    ST_MASK,
    ST_MODDATA,
    ST_STATUS,
    ST_RSTARM,
    ST_SKIP
  } cmd_state_e;

  typedef enum logic [1:0] {
    ACC_READ,
    ACC_WRITE,
    ACC_MODIFY
  } access_e;

  // strobes from the command sequencer to the datapath
  typedef struct packed {
    logic addrLoad;
    logic addrInc;
    logic fetch;
    logic loadStatus;
    logic wrNow;
    logic maskLoad;
    logic modStart;
  } dp_strobe_t;

endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= RST_VAL;
    end else begin
      stage[0] <= din;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/spi_cmd_dp.sv
module spi_cmd_dp import spi_cmd_pkg::*; #(
  parameter int ADDR_W = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spiSck,
  input  logic              spiCsN,
  input  logic              spiSi,
  input  dp_strobe_t        stb,
  output logic              byteDone,
  output logic [BYTE_W-1:0] rxByte,
  output logic              csIdle,
  output logic              csRise,
  output logic              spiSo,
  output logic              spiSoOe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWrData,
  output logic              regWe,
  input  logic [BYTE_W-1:0] regRdData,
  input  logic [1:0]        rxIntFlag,
  input  logic [TX_BUFS-1:0] txReqFlag,
  input  logic [TX_BUFS-1:0] txIntFlag
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam int RD_LAT = 2;

  logic [2:0] syncOut;
  logic sckS, csS, siS;
  logic sckD, csD;
  logic sckRise, sckFall;

  spi_cmd_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) i_sync (
    .clk (clk),
    .rst (rst),
    .din ({spiSck, spiCsN, spiSi}),
    .dout(syncOut)
  );

  assign sckS = syncOut[2];
  assign csS  = syncOut[1];
  assign siS  = syncOut[0];

  assign sckRise = sckS & ~sckD;
  assign sckFall = ~sckS & sckD;
  assign csRise  = csS & ~csD;
  assign csIdle  = csS;

  // receive shifter and bit counter
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-2:0] rxShift;

  always_ff @(posedge clk) begin
    if (rst) begin
      sckD <= 1'b0;
      csD <= 1'b1;
      bitCnt <= '0;
      rxShift <= '0;
      rxByte <= '0;
      byteDone <= 1'b0;
    end else begin
      sckD <= sckS;
      csD <= csS;
      byteDone <= 1'b0;
      if (csS) begin
        bitCnt <= '0;
      end else if (sckRise) begin
        rxShift <= {rxShift[BYTE_W-3:0], siS};
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt == CNT_W'(BYTE_W - 1)) begin
          rxByte <= {rxShift, siS};
          byteDone <= 1'b1;
        end
      end
    end
  end

  // address counter, wraps naturally at the top of the space
  logic [ADDR_W-1:0] addrQ;

  always_ff @(posedge clk) begin
    if (rst) addrQ <= '0;
    else if (stb.addrLoad) addrQ <= rxByte[ADDR_W-1:0];
    else if (stb.addrInc) addrQ <= addrQ + 1'b1;
  end

  assign regAddr = addrQ;

  // read-latency pipes for data fetch and read-modify-write
  logic [RD_LAT-1:0] fetchPipe, modPipe;
  logic [BYTE_W-1:0] maskQ, modDataQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      fetchPipe <= '0;
      modPipe <= '0;
      maskQ <= '0;
      modDataQ <= '0;
    end else begin
      fetchPipe <= {fetchPipe[RD_LAT-2:0], stb.fetch};
      modPipe <= {modPipe[RD_LAT-2:0], stb.modStart};
      if (stb.maskLoad) maskQ <= rxByte;
      if (stb.modStart) modDataQ <= rxByte;
    end
  end

  logic modWrite;
  assign modWrite = modPipe[RD_LAT-1];
  assign regWe = stb.wrNow | modWrite;
  assign regWrData = modWrite ? ((regRdData & ~maskQ) | (modDataQ & maskQ)) : rxByte;

  // status byte: two rx flags, then request/flag pairs per transmit buffer
  logic [BYTE_W-1:0] statusByte;
  assign statusByte[1:0] = rxIntFlag;
  for (genvar i = 0; i < TX_BUFS; i++) begin : g_status
    assign statusByte[2 + 2*i] = txReqFlag[i];
    assign statusByte[3 + 2*i] = txIntFlag[i];
  end

  // transmit shifter
  logic [BYTE_W-1:0] txShift;
  logic txActive;

  always_ff @(posedge clk) begin
    if (rst) begin
      txShift <= '0;
      txActive <= 1'b0;
    end else if (csS) begin
      txActive <= 1'b0;
    end else if (stb.loadStatus) begin
      txShift <= statusByte;
      txActive <= 1'b1;
    end else if (fetchPipe[RD_LAT-1]) begin
      txShift <= regRdData;
      txActive <= 1'b1;
    end else if (sckFall && txActive && bitCnt != '0) begin
      txShift <= {txShift[BYTE_W-2:0], 1'b0};
    end
  end

  assign spiSo = txActive & txShift[BYTE_W-1];
  assign spiSoOe = txActive;

endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl import spi_cmd_pkg::*; (
  input  logic               clk,
  input  logic               rst,
  input  logic               byteDone,
  input  logic [BYTE_W-1:0]  rxByte,
  input  logic               csIdle,
  input  logic               csRise,
  output dp_strobe_t         stb,
  output logic [TX_BUFS-1:0] rtsPulse,
  output logic               softReset
);

  cmd_state_e state, nextState;
  access_e accQ, nextAcc;
  logic [TX_BUFS-1:0] rtsNext;

  always_comb begin
    stb = '0;
    nextState = state;
    nextAcc = accQ;
    rtsNext = '0;
    if (csIdle) begin
      nextState = ST_OPCODE;
    end else if (byteDone) begin
      case (state)
        ST_OPCODE: begin
          if (rxByte == OPC_READ) begin
            nextAcc = ACC_READ;
            nextState = ST_ADDR;
          end else if (rxByte == OPC_WRITE) begin
            nextAcc = ACC_WRITE;
            nextState = ST_ADDR;
          end else if (rxByte == OPC_MODIFY) begin
            nextAcc = ACC_MODIFY;
            nextState = ST_ADDR;
          end else if (rxByte == OPC_STATUS) begin
            stb.loadStatus = 1'b1;
            nextState = ST_STATUS;
          end else if (rxByte == OPC_RESET) begin
            nextState = ST_RSTARM;
          end else if (rxByte[7:3] == OPC_RTS_HI) begin
            rtsNext = rxByte[TX_BUFS-1:0];
            nextState = ST_SKIP;
          end else begin
            nextState = ST_SKIP;
          end
        end
        ST_ADDR: begin
          stb.addrLoad = 1'b1;
          case (accQ)
            ACC_READ: begin
              stb.fetch = 1'b1;
              nextState = ST_RDDATA;
            end
            ACC_WRITE: nextState = ST_WRDATA;
            default: nextState = ST_MASK;
          endcase
        end
        ST_RDDATA: begin
          stb.addrInc = 1'b1;
          stb.fetch = 1'b1;
        end
        ST_WRDATA: begin
          stb.wrNow = 1'b1;
          stb.addrInc = 1'b1;
        end
        ST_MASK: begin
          stb.maskLoad = 1'b1;
          nextState = ST_MODDATA;
        end
        ST_MODDATA: begin
          stb.modStart = 1'b1;
          nextState = ST_SKIP;
        end
        ST_STATUS: stb.loadStatus = 1'b1;
        default: nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_OPCODE;
      accQ <= ACC_READ;
      rtsPulse <= '0;
      softReset <= 1'b0;
    end else begin
      state <= nextState;
      accQ <= nextAcc;
      rtsPulse <= rtsNext;
      softReset <= csRise && (state == ST_RSTARM);
    end
  end

endmodule

// File: rtl/spi_cmd_port.sv
module spi_cmd_port import spi_cmd_pkg::*; #(
  parameter int ADDR_W = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spiSck,
  input  logic              spiCsN,
  input  logic              spiSi,
  output logic              spiSo,
  output logic              spiSoOe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [7:0]        regWrData,
  output logic              regWe,
  input  logic [7:0]        regRdData,
  input  logic [1:0]        rxIntFlag,
  input  logic [2:0]        txReqFlag,
  input  logic [2:0]        txIntFlag,
  output logic [2:0]        rtsPulse,
  output logic              softReset
);

  dp_strobe_t stb;
  logic byteDone, csIdle, csRise;
  logic [BYTE_W-1:0] rxByte;

  spi_cmd_dp #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk      (clk),
    .rst      (rst),
    .spiSck   (spiSck),
    .spiCsN   (spiCsN),
    .spiSi    (spiSi),
    .stb      (stb),
    .byteDone (byteDone),
    .rxByte   (rxByte),
    .csIdle   (csIdle),
    .csRise   (csRise),
    .spiSo    (spiSo),
    .spiSoOe  (spiSoOe),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .regWe    (regWe),
    .regRdData(regRdData),
    .rxIntFlag(rxIntFlag),
    .txReqFlag(txReqFlag),
    .txIntFlag(txIntFlag)
  );

  spi_cmd_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .byteDone (byteDone),
    .rxByte   (rxByte),
    .csIdle   (csIdle),
    .csRise   (csRise),
    .stb      (stb),
    .rtsPulse (rtsPulse),
    .softReset(softReset)
  );

endmodule

// File: rtl/spi_cmd_port_chk.sv
module spi_cmd_port_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       spiCsN,
  input logic       spiSoOe,
  input logic       regWe,
  input logic [2:0] rtsPulse,
  input logic       softReset
);

  localparam int SETTLE = SYNC_STAGES + 1;
  localparam int CNT_W = $clog2(SETTLE + 2);

  logic [CNT_W-1:0] csHighCnt;

  always_ff @(posedge clk) begin
    if (rst) csHighCnt <= '0;
    else if (!spiCsN) csHighCnt <= '0;
    else if (csHighCnt < CNT_W'(SETTLE)) csHighCnt <= csHighCnt + 1'b1;
  end

  // R9
  so_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (csHighCnt >= CNT_W'(SETTLE)) |-> !spiSoOe);

  // R8
  soft_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    softReset |=> !softReset);

  // R8
  soft_released_chk: assert property (@(posedge clk) disable iff (rst)
    softReset |-> spiCsN);

  // R7
  rts_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (|rtsPulse) |=> (rtsPulse == 3'b000));

  // R4
  write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    regWe |-> !spiSoOe);

endmodule

bind spi_cmd_port spi_cmd_port_chk #(.SYNC_STAGES(SYNC_STAGES)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .spiCsN   (spiCsN),
  .spiSoOe  (spiSoOe),
  .regWe    (regWe),
  .rtsPulse (rtsPulse),
  .softReset(softReset)
);

// File: tb/test_spi_cmd_port.sv
`timescale 1ns/1ps
module test_spi_cmd_port;

  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spiSck = 1'b0;
  logic spiCsN = 1'b1;
  logic spiSi = 1'b0;
  logic spiSo, spiSoOe, regWe, softReset;
  logic [6:0] regAddr;
  logic [7:0] regWrData;
  logic [7:0] regRdData;
  logic [1:0] rxIntFlag = 2'b00;
  logic [2:0] txReqFlag = 3'b000;
  logic [2:0] txIntFlag = 3'b000;
  logic [2:0] rtsPulse;

  always #2 clk = ~clk;

  spi_cmd_port i_spi_cmd_port (
    .clk(clk), .rst(rst), .spiSck(spiSck), .spiCsN(spiCsN), .spiSi(spiSi),
    .spiSo(spiSo), .spiSoOe(spiSoOe), .regAddr(regAddr), .regWrData(regWrData),
    .regWe(regWe), .regRdData(regRdData), .rxIntFlag(rxIntFlag),
    .txReqFlag(txReqFlag), .txIntFlag(txIntFlag), .rtsPulse(rtsPulse),
    .softReset(softReset)
  );

  function automatic logic [7:0] initVal(int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  // register file model with registered read
  logic [7:0] mem [128];
  logic [7:0] refMem [128];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 128; i++) mem[i] <= initVal(i);
    end else if (regWe) begin
      mem[regAddr] <= regWrData;
    end
    regRdData <= mem[regAddr];
  end
  initial for (int i = 0; i < 128; i++) refMem[i] = initVal(i);

  int rtsCnt [3] = '{0, 0, 0};
  int softCnt = 0;
  always @(posedge clk) begin
    if (!rst) begin
      for (int i = 0; i < 3; i++) if (rtsPulse[i]) rtsCnt[i]++;
      if (softReset) softCnt++;
    end
  end

  int checks = 0;
  int fails = 0;
  bit mode11 = 1'b0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  // scoreboard: kind 0 = don't care, 1 = expect value driven, 2 = expect undriven
  int kindQ [$];
  logic [7:0] valQ [$];
  string tagQ [$];

  int monBits = 0;
  int monOe = 0;
  logic [7:0] monSh = 8'h00;
  int mKind;
  logic [7:0] mVal;
  string mTag;

  always @(posedge spiSck or posedge spiCsN) begin
    if (spiCsN) begin
      monBits = 0;
      monOe = 0;
    end else begin
      monSh = {monSh[6:0], spiSo};
      if (spiSoOe) monOe++;
      monBits++;
      if (monBits == 8) begin
        if (kindQ.size() == 0) begin
          chk(1'b0, "R9", 1, 0);
        end else begin
          mKind = kindQ.pop_front();
          mVal = valQ.pop_front();
          mTag = tagQ.pop_front();
          if (mKind == 1) begin
            chk(monOe == 8, mTag, monOe, 8);
            chk(monSh == mVal, mTag, monSh, mVal);
          end else if (mKind == 2) begin
            chk(monOe == 0, mTag, monOe, 0);
          end
        end
        monBits = 0;
        monOe = 0;
      end
    end
  end

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic csLow();
    spiSck = mode11;
    waitClk(HALF);
    spiCsN = 1'b0;
    waitClk(HALF);
  endtask

  task automatic csHigh();
    if (!mode11) spiSck = 1'b0;
    waitClk(HALF);
    spiCsN = 1'b1;
    waitClk(4 * HALF);
  endtask

  task automatic sendBits(logic [7:0] b, int n);
    for (int i = 0; i < n; i++) begin
      if (mode11) spiSck = 1'b0;
      spiSi = b[7-i];
      waitClk(HALF);
      spiSck = 1'b1;
      waitClk(HALF);
      if (!mode11) spiSck = 1'b0;
    end
  endtask

  task automatic xfer(logic [7:0] b, int kind, logic [7:0] expv, string tag);
    kindQ.push_back(kind);
    valQ.push_back(expv);
    tagQ.push_back(tag);
    sendBits(b, 8);
  endtask

  task automatic spiWrite(logic [6:0] a, logic [7:0] d [4], int n);
    logic [6:0] ai;
    csLow();
    xfer(8'h02, 2, 8'h00, "R9");
    xfer({1'b0, a}, 2, 8'h00, "R9");
    for (int i = 0; i < n; i++) begin
      ai = a + 7'(i);
      xfer(d[i], 2, 8'h00, "R4");
      refMem[ai] = d[i];
    end
    csHigh();
  endtask

  task automatic spiRead(logic [6:0] a, int n, string tag);
    logic [6:0] ai;
    csLow();
    xfer(8'h03, 2, 8'h00, "R9");
    xfer({1'b0, a}, 2, 8'h00, "R9");
    for (int i = 0; i < n; i++) begin
      ai = a + 7'(i);
      xfer(8'h00, 1, refMem[ai], tag);
    end
    csHigh();
    chk(spiSoOe == 1'b0, "R9", spiSoOe, 0);
  endtask

  task automatic spiModify(logic [6:0] a, logic [7:0] mask, logic [7:0] data);
    csLow();
    xfer(8'h05, 2, 8'h00, "R9");
    xfer({1'b0, a}, 2, 8'h00, "R9");
    xfer(mask, 2, 8'h00, "R5");
    xfer(data, 2, 8'h00, "R5");
    csHigh();
    refMem[a] = (refMem[a] & ~mask) | (data & mask);
  endtask

  function automatic logic [7:0] packStatus();
    return {txIntFlag[2], txReqFlag[2], txIntFlag[1], txReqFlag[1],
            txIntFlag[0], txReqFlag[0], rxIntFlag[1], rxIntFlag[0]};
  endfunction

  task automatic spiStatus(int n, string tag);
    csLow();
    xfer(8'hA0, 2, 8'h00, "R9");
    for (int i = 0; i < n; i++) xfer(8'h00, 1, packStatus(), tag);
    csHigh();
  endtask

  task automatic spiCmd(logic [7:0] op, string tag);
    csLow();
    xfer(op, 2, 8'h00, tag);
    csHigh();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R1", 0, 1);
    finishRun();
  end

  initial begin
    int r0, r1, r2, s0;
    waitClk(5);
    chk(spiSoOe == 1'b0, "R9", spiSoOe, 0);
    chk(regWe == 1'b0, "R4", regWe, 0);
    chk(rtsPulse == 3'b000, "R7", rtsPulse, 0);
    chk(softReset == 1'b0, "R8", softReset, 0);
    rst = 1'b0;
    waitClk(10);

    // R4 / R3: sequential write and read, mode 0,0
    spiWrite(7'h10, '{8'h11, 8'h22, 8'h33, 8'h00}, 3);
    spiRead(7'h10, 3, "R3");

    // R4: write across the top of the space
    spiWrite(7'h7E, '{8'hA1, 8'hA2, 8'hA3, 8'hA4}, 4);
    spiRead(7'h7E, 4, "R4");
    spiRead(7'h7F, 3, "R3");

    // R2: same accesses with the serial clock idling high
    mode11 = 1'b1;
    spiRead(7'h7F, 3, "R2");
    spiWrite(7'h40, '{8'h5C, 8'hC5, 8'h00, 8'h00}, 2);
    spiRead(7'h40, 2, "R2");
    mode11 = 1'b0;

    // R5: masked modify, then a zero mask
    spiWrite(7'h20, '{8'hF0, 8'h00, 8'h00, 8'h00}, 1);
    spiModify(7'h20, 8'h3C, 8'hAA);
    spiRead(7'h20, 1, "R5");
    chk(refMem[7'h20] == 8'hE8, "R5", refMem[7'h20], 8'hE8);
    spiModify(7'h20, 8'h00, 8'hFF);
    spiRead(7'h20, 1, "R5");
    spiModify(7'h20, 8'hFF, 8'h0F);
    spiRead(7'h20, 1, "R5");

    // R6: status packing in both clock modes
    rxIntFlag = 2'b01; txReqFlag = 3'b101; txIntFlag = 3'b010;
    chk(packStatus() == 8'h65, "R6", packStatus(), 8'h65);
    spiStatus(2, "R6");
    rxIntFlag = 2'b10; txReqFlag = 3'b010; txIntFlag = 3'b101;
    mode11 = 1'b1;
    spiStatus(3, "R6");
    mode11 = 1'b0;

    // R7: request-to-send strobes
    r0 = rtsCnt[0]; r1 = rtsCnt[1]; r2 = rtsCnt[2];
    spiCmd(8'h85, "R7");
    chk(rtsCnt[0] == r0 + 1, "R7", rtsCnt[0], r0 + 1);
    chk(rtsCnt[1] == r1, "R7", rtsCnt[1], r1);
    chk(rtsCnt[2] == r2 + 1, "R7", rtsCnt[2], r2 + 1);
    mode11 = 1'b1;
    spiCmd(8'h87, "R7");
    mode11 = 1'b0;
    chk(rtsCnt[0] == r0 + 2, "R7", rtsCnt[0], r0 + 2);
    chk(rtsCnt[1] == r1 + 1, "R7", rtsCnt[1], r1 + 1);
    chk(rtsCnt[2] == r2 + 2, "R7", rtsCnt[2], r2 + 2);
    spiCmd(8'h80, "R7");
    chk(rtsCnt[0] + rtsCnt[1] + rtsCnt[2] == r0 + r1 + r2 + 5, "R7",
        rtsCnt[0] + rtsCnt[1] + rtsCnt[2], r0 + r1 + r2 + 5);

    // R8: soft reset waits for chip select release
    s0 = softCnt;
    csLow();
    xfer(8'hC0, 2, 8'h00, "R8");
    waitClk(40);
    chk(softCnt == s0, "R8", softCnt, s0);
    csHigh();
    chk(softCnt == s0 + 1, "R8", softCnt, s0 + 1);

    // R1: unknown opcodes are ignored
    r0 = rtsCnt[0] + rtsCnt[1] + rtsCnt[2];
    s0 = softCnt;
    csLow();
    xfer(8'h06, 2, 8'h00, "R1");
    xfer(8'h10, 2, 8'h00, "R1");
    xfer(8'h99, 2, 8'h00, "R1");
    csHigh();
    spiCmd(8'h88, "R1");
    spiCmd(8'h00, "R1");
    chk(rtsCnt[0] + rtsCnt[1] + rtsCnt[2] == r0, "R1",
        rtsCnt[0] + rtsCnt[1] + rtsCnt[2], r0);
    chk(softCnt == s0, "R1", softCnt, s0);
    spiRead(7'h10, 1, "R1");

    // R10: chip select raised mid-byte
    csLow();
    xfer(8'h02, 2, 8'h00, "R10");
    xfer(8'h30, 2, 8'h00, "R10");
    sendBits(8'hFF, 5);
    csHigh();
    spiRead(7'h30, 1, "R10");
    csLow();
    sendBits(8'h03, 3);
    csHigh();
    spiWrite(7'h31, '{8'h7E, 8'h00, 8'h00, 8'h00}, 1);
    spiRead(7'h30, 2, "R10");

    chk(kindQ.size() == 0, "R3", kindQ.size(), 0);
    finishRun();
  end

endmodule